// File: doc/BRIEF.md
# Completion Ring Posting Engine

This block posts completion records into a circular completion ring that lives in host memory. Several command sources, each standing for one submission queue, hand it completion requests over independent valid/ready channels. The engine picks one source at a time in rotating order and builds a 16-byte record. The record carries the answering queue's identifier and its current head pointer, the command tag that software chose, a status code and a phase flag. The engine then emits the record as a single write at the ring's current tail slot, moves the tail on by one slot and pulses an interrupt request once the write has been taken.

The host consumes records and returns slots by writing its new head index to a doorbell port; each write replaces the previous head. The phase flag starts at 1 and inverts every time the tail wraps back to slot 0. This lets the host tell fresh records from stale ones without reading any device register. The ring is full when advancing the tail would make it equal to the head. While the ring is full, no source is granted and every pending request waits with its valid held. Writing the configuration port sets the ring base and the slot count (at least 2). It also restarts the tail and head at 0, the phase at 1 and clears the doorbell error flag.

Back-pressure rules: a source request is taken in the cycle where its `req_valid` and `req_ready` bits are both high. A source must hold its valid and fields until then. The memory write is taken when `mem_valid` and `mem_ready` are both high, and the engine holds address and data unchanged while `mem_ready` is low. One record may wait in the output register, and a new grant can be made in the same cycle the waiting one is taken. A configuration write blocks grants in its cycle.

Top module: `cq_post_engine`

## Requirements
- R1: The written record has this layout: bits [31:0] the command-specific word from the request, [63:32] zero, [79:64] the submission queue head, [95:80] the submission queue identifier, [111:96] the command tag, [112] the phase flag, [127:113] the 15-bit status.
- R2: Each record is written at address base + 16 × tail. The tail moves by one per record and goes back to 0 after slot size−1, so the writes follow grant order.
- R3: The phase flag is 1 after reset or configuration and inverts each time the tail wraps from size−1 to 0.
- R4: When (tail+1) mod size equals the head, no request is granted, and a pending request stays pending until a doorbell frees a slot.
- R5: A doorbell value below the ring size replaces the head, which frees the slots the host has consumed.
- R6: A doorbell value at or above the ring size leaves the head unchanged and sets `db_err`, which stays high until the next configuration write.
- R7: Requests are granted one per cycle at most, only to a source whose valid is high, in round-robin order starting after the last granted source (source 0 first after reset).
- R8: `irq_req` is high for exactly the cycle after each accepted memory write, and low otherwise.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay unchanged.
- R10: A configuration write loads base and size, returns tail and head to 0 and the phase to 1, and clears `db_err`.
- R11: After reset, `mem_valid`, `irq_req`, `db_err` and all `req_ready` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | AW | Ring base byte address |
| cfg_size | input | IW | Ring slot count (at least 2) |
| req_valid | input | NSRC | Per-source request valid |
| req_ready | output | NSRC | Per-source grant |
| req_dw0 | input | NSRC×32 | Per-source command-specific word |
| req_sqid | input | NSRC×16 | Per-source submission queue identifier |
| req_sqhead | input | NSRC×16 | Per-source submission queue head |
| req_status | input | NSRC×15 | Per-source status code |
| req_cid | input | NSRC×16 | Per-source command tag |
| db_we | input | 1 | Head doorbell write strobe |
| db_head | input | IW | New host head index |
| mem_valid | output | 1 | Record write valid |
| mem_ready | input | 1 | Record write accepted |
| mem_addr | output | AW | Record byte address |
| mem_data | output | 128 | Record contents |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| db_err | output | 1 | Sticky out-of-range doorbell flag |

## Verification
The hardest overlap is a head doorbell that lands in the same cycle as a grant decision at the full boundary. The grant must use the old head, and the new head must free slots only from the next cycle on. The random phase sends doorbells carrying the host's written-slot index with high probability while all sources keep the ring close to full. A reference model in the bench judges this by updating its head only after it has predicted each cycle's grant. The same model also covers a memory accept that coincides with a new grant into the output register, and checks that the record order and phase flags are unchanged.

// File: rtl/cqp_pkg.sv
package cqp_pkg;
  localparam int SPEC_W  = 32;
  localparam int SQID_W  = 16;
  localparam int SQHD_W  = 16;
  localparam int STAT_W  = 15;
  localparam int CID_W   = 16;
  localparam int ENTRY_W = 128;
  localparam int SLOT_LG = 4;

  typedef struct packed {
    logic [SPEC_W-1:0] spec;
    logic [SQID_W-1:0] sqid;
    logic [SQHD_W-1:0] sqhead;
    logic [STAT_W-1:0] status;
    logic [CID_W-1:0]  cid;
  } cpl_req_t;

  function automatic logic [ENTRY_W-1:0] build_entry(cpl_req_t r, logic ph);
    return {r.status, ph, r.cid, r.sqid, r.sqhead, 32'h0, r.spec};
  endfunction
endpackage

// File: rtl/cqp_rr_arb.sv
module cqp_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last_q;
  logic [PW-1:0] win;
  logic          found;
  int            j;

  always_comb begin
    gnt   = '0;
    win   = last_q;
    found = 1'b0;
    j     = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last_q) + k) % N;
      if (!found && req[j]) begin
        found  = 1'b1;
        gnt[j] = 1'b1;
        win    = PW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= PW'(N - 1);
    else if (take) last_q <= win;
  end
endmodule

// File: rtl/cqp_ring_ctrl.sv
module cqp_ring_ctrl #(
  parameter int IW         = 8,
  parameter int RESET_SIZE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_size,
  input  logic          adv,
  input  logic          db_we,
  input  logic [IW-1:0] db_val,
  output logic [IW-1:0] tail,
  output logic          phase,
  output logic          full,
  output logic          db_err
);
  logic [IW-1:0] size_q, head_q, tail_q, tail_nxt;
  logic          phase_q, err_q, wrap, db_ok;

  assign wrap     = (tail_q == size_q - 1'b1);
  assign tail_nxt = wrap ? '0 : tail_q + 1'b1;
  assign full     = (tail_nxt == head_q);
  assign db_ok    = (db_val < size_q);
  assign tail     = tail_q;
  assign phase    = phase_q;
  assign db_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= IW'(RESET_SIZE);
      head_q  <= '0;
      tail_q  <= '0;
      phase_q <= 1'b1;
      err_q   <= 1'b0;
    end else if (cfg_we) begin
      size_q  <= cfg_size;
      head_q  <= '0;
      tail_q  <= '0;
      phase_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      if (adv) begin
        tail_q <= tail_nxt;
        if (wrap) phase_q <= ~phase_q;
      end
      if (db_we) begin
        if (db_ok) head_q <= db_val;
        else       err_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cqp_out_stage.sv
module cqp_out_stage #(
  parameter int AW = 32,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          mem_ready,
  output logic          can_load,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          irq
);
  logic vld_q, fire;

  assign fire      = vld_q && mem_ready;
  assign can_load  = !vld_q || mem_ready;
  assign mem_valid = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= fire;
      if (load) begin
        vld_q    <= 1'b1;
        mem_addr <= load_addr;
        mem_data <= load_data;
      end else if (fire) begin
        vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine #(
  parameter int NSRC       = 4,
  parameter int AW         = 32,
  parameter int IW         = 8,
  parameter int RESET_SIZE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_base,
  input  logic [IW-1:0]      cfg_size,
  input  logic [NSRC-1:0]    req_valid,
  output logic [NSRC-1:0]    req_ready,
  input  logic [NSRC*32-1:0] req_dw0,
  input  logic [NSRC*16-1:0] req_sqid,
  input  logic [NSRC*16-1:0] req_sqhead,
  input  logic [NSRC*15-1:0] req_status,
  input  logic [NSRC*16-1:0] req_cid,
  input  logic               db_we,
  input  logic [IW-1:0]      db_head,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [AW-1:0]      mem_addr,
  output logic [127:0]       mem_data,
  output logic               irq_req,
  output logic               db_err
);
  import cqp_pkg::*;
  localparam int RW = $bits(cpl_req_t);

  cpl_req_t      reqs [NSRC];
  logic [RW-1:0] sel_bits;
  cpl_req_t      sel;
  logic [NSRC-1:0] gnt;
  logic [AW-1:0] base_q, slot_addr;
  logic [IW-1:0] tail;
  logic          phase, ring_full, can_load, take;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign reqs[g].spec   = req_dw0   [g*SPEC_W +: SPEC_W];
    assign reqs[g].sqid   = req_sqid  [g*SQID_W +: SQID_W];
    assign reqs[g].sqhead = req_sqhead[g*SQHD_W +: SQHD_W];
    assign reqs[g].status = req_status[g*STAT_W +: STAT_W];
    assign reqs[g].cid    = req_cid   [g*CID_W  +: CID_W];
  end

  always_comb begin
    sel_bits = '0;
    for (int i = 0; i < NSRC; i++)
      if (gnt[i]) sel_bits = sel_bits | reqs[i];
  end
  assign sel = cpl_req_t'(sel_bits);

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (cfg_we) base_q <= cfg_base;
  end

  assign take      = (|gnt) && can_load && !ring_full && !cfg_we;
  assign req_ready = take ? gnt : '0;
  assign slot_addr = base_q + (AW'(tail) << SLOT_LG);

  cqp_rr_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .take(take), .gnt(gnt)
  );

  cqp_ring_ctrl #(.IW(IW), .RESET_SIZE(RESET_SIZE)) u_ring (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .adv(take), .db_we(db_we), .db_val(db_head),
    .tail(tail), .phase(phase), .full(ring_full), .db_err(db_err)
  );

  cqp_out_stage #(.AW(AW), .DW(ENTRY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(take), .load_addr(slot_addr),
    .load_data(build_entry(sel, phase)), .mem_ready(mem_ready),
    .can_load(can_load), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq_req)
  );
endmodule

// File: rtl/cqp_checker.sv
module cqp_checker #(
  parameter int NSRC = 4,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_valid,
  input logic [NSRC-1:0] req_ready,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [127:0]    mem_data,
  input logic            irq_req,
  input logic            db_err,
  input logic            cfg_we,
  input logic            full
);
  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  // R7
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> req_ready == '0);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R8
  irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> irq_req);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_ready) |=> !irq_req);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_err && !cfg_we |=> db_err);
  // R10
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !db_err);
endmodule

bind cq_post_engine cqp_checker #(.NSRC(NSRC), .AW(AW)) u_cqp_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .irq_req(irq_req), .db_err(db_err),
  .cfg_we(cfg_we), .full(ring_full)
);

// File: tb/cq_post_engine_test.sv
module cq_post_engine_test;
  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [IW-1:0] cfg_size = '0;
  logic [NS-1:0] req_valid, req_ready;
  logic [NS*32-1:0] req_dw0;
  logic [NS*16-1:0] req_sqid, req_sqhead, req_cid;
  logic [NS*15-1:0] req_status;
  logic db_we = 1'b0;
  logic [IW-1:0] db_head = '0;
  logic mem_valid, mem_ready = 1'b0, irq_req, db_err;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_data;

  logic        s_valid [NS];
  logic [31:0] s_dw0   [NS];
  logic [15:0] s_sqid  [NS], s_sqh [NS], s_cid [NS];
  logic [14:0] s_st    [NS];
  logic        hs      [NS];

  always_comb
    for (int i = 0; i < NS; i++) begin
      req_valid[i]          = s_valid[i];
      req_dw0[i*32 +: 32]   = s_dw0[i];
      req_sqid[i*16 +: 16]  = s_sqid[i];
      req_sqhead[i*16 +: 16]= s_sqh[i];
      req_cid[i*16 +: 16]   = s_cid[i];
      req_status[i*15 +: 15]= s_st[i];
    end

  cq_post_engine #(.NSRC(NS), .AW(AW), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .req_valid(req_valid), .req_ready(req_ready),
    .req_dw0(req_dw0), .req_sqid(req_sqid), .req_sqhead(req_sqhead),
    .req_status(req_status), .req_cid(req_cid), .db_we(db_we),
    .db_head(db_head), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .irq_req(irq_req),
    .db_err(db_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] f_entry(logic [31:0] dw0, logic [15:0] sqid,
      logic [15:0] sqh, logic [14:0] st, logic [15:0] cid, logic ph);
    return {st, ph, cid, sqid, sqh, 32'h0, dw0};
  endfunction

  // reference model
  int b_size = 16, b_tail = 0, b_head = 0, b_wtail = 0, b_rr = NS - 1, b_writes = 0;
  logic [31:0] b_base = '0;
  bit b_phase = 1'b1, b_err = 1'b0, prev_wr = 1'b0, prev_stall = 1'b0;
  logic [31:0]  prev_addr;
  logic [127:0] prev_data;
  logic [31:0]  q_addr [256];
  logic [127:0] q_data [256];
  int q_wr = 0, q_rd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit full = (((b_tail + 1) % b_size) == b_head);
      automatic int win = -1;
      automatic logic [NS-1:0] exp_rdy = '0;
      chk(irq_req == prev_wr, "R8", "irq pulse", irq_req, prev_wr);
      chk(db_err == b_err, "R6", "error flag", db_err, b_err);
      if (prev_stall) begin
        chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data, "R9",
            "held write", mem_data, prev_data);
      end
      if (|req_valid && !full && !cfg_we && (!mem_valid || mem_ready)) begin
        for (int k = 1; k <= NS; k++)
          if (win < 0 && req_valid[(b_rr + k) % NS]) win = (b_rr + k) % NS;
        exp_rdy[win] = 1'b1;
      end
      chk(req_ready == exp_rdy, full ? "R4" : "R7", "grant", req_ready, exp_rdy);
      if (mem_valid && mem_ready) begin
        chk(q_rd != q_wr, "R2", "unexpected write", mem_addr, 0);
        if (q_rd != q_wr) begin
          chk(mem_addr == q_addr[q_rd % 256], "R2", "slot address", mem_addr, q_addr[q_rd % 256]);
          chk(mem_data[112] == q_data[q_rd % 256][112], "R3", "phase flag",
              mem_data[112], q_data[q_rd % 256][112]);
          chk(mem_data == q_data[q_rd % 256], "R1", "record layout", mem_data, q_data[q_rd % 256]);
          q_rd++;
        end
        b_wtail = (b_wtail + 1) % b_size;
        b_writes++;
        prev_wr = 1'b1;
      end else prev_wr = 1'b0;
      for (int i = 0; i < NS; i++)
        if (req_valid[i] && req_ready[i]) begin
          hs[i] = 1'b1;
          q_addr[q_wr % 256] = b_base + 32'(b_tail) * 16;
          q_data[q_wr % 256] = f_entry(s_dw0[i], s_sqid[i], s_sqh[i], s_st[i], s_cid[i], b_phase);
          q_wr++;
          b_rr = i;
          if (b_tail == b_size - 1) begin b_tail = 0; b_phase = ~b_phase; end
          else b_tail++;
        end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_data  = mem_data;
      if (cfg_we) begin
        b_size = int'(cfg_size); b_base = cfg_base; b_tail = 0; b_head = 0;
        b_wtail = 0; b_phase = 1'b1; b_err = 1'b0;
      end else if (db_we) begin
        if (int'(db_head) < b_size) b_head = int'(db_head);
        else b_err = 1'b1;
      end
    end
  end

  // stimulus controls
  logic [NS-1:0] en_mask = '0;
  int p_valid = 0, p_ready = 100, p_db = 0;
  bit auto_db = 1'b0;

  task automatic new_fields(int i);
    s_dw0[i]  = $urandom;
    s_sqid[i] = 16'($urandom);
    s_sqh[i]  = 16'($urandom);
    s_cid[i]  = 16'($urandom);
    s_st[i]   = 15'($urandom);
  endtask

  task automatic step();
    @(posedge clk); #1;
    for (int i = 0; i < NS; i++) begin
      if (hs[i] || !s_valid[i]) begin
        if (hs[i]) new_fields(i);
        hs[i] = 1'b0;
        s_valid[i] = en_mask[i] && (($urandom % 100) < p_valid);
      end
    end
    mem_ready = ($urandom % 100) < p_ready;
    db_we = 1'b0;
    if (auto_db && (($urandom % 100) < p_db)) begin
      db_we = 1'b1;
      db_head = (($urandom % 25) == 0) ? IW'(b_size + int'($urandom % 4)) : IW'(b_wtail);
    end
  endtask

  task automatic configure(int size, logic [31:0] base);
    step();
    cfg_we = 1'b1; cfg_size = IW'(size); cfg_base = base;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    en_mask = '0; auto_db = 1'b0; p_ready = 100;
    for (int n = 0; n < 60; n++) begin
      step();
      if (!(|req_valid) && !mem_valid) break;
      db_we = 1'b1; db_head = IW'(b_wtail);
    end
    step();
  endtask

  bit done = 1'b0;
  initial begin
    automatic int seed_dummy = $urandom(32'd20250611);
    for (int i = 0; i < NS; i++) begin s_valid[i] = 1'b0; hs[i] = 1'b0; new_fields(i); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!mem_valid && !irq_req && !db_err && req_ready == '0, "R11", "reset outputs",
        {mem_valid, irq_req, db_err, req_ready}, 0);

    // directed: fill a 5-slot ring from one source
    configure(5, 32'h0000_1000);
    @(negedge clk);
    chk(db_err == 1'b0, "R10", "error after config", db_err, 0);
    en_mask = 4'b0100; p_valid = 100; p_ready = 100;
    repeat (20) step();
    @(negedge clk);
    chk(b_writes == 4, "R4", "writes before full", b_writes, 4);
    chk(req_valid[2] && req_ready == '0, "R4", "pending request held", req_ready, 0);
    step(); db_we = 1'b1; db_head = 8'd7;
    repeat (6) step();
    @(negedge clk);
    chk(db_err == 1'b1, "R6", "out-of-range doorbell flag", db_err, 1);
    chk(b_writes == 4 && req_ready == '0, "R6", "head unchanged after bad doorbell", b_writes, 4);
    step(); db_we = 1'b1; db_head = 8'd4;
    repeat (20) step();
    @(negedge clk);
    chk(b_writes == 8, "R5", "slots freed by doorbell", b_writes, 8);
    chk(req_ready == '0, "R4", "full again after wrap", req_ready, 0);
    drain();

    // random traffic on an 8-slot ring
    configure(8, 32'h0000_2000);
    @(negedge clk);
    chk(db_err == 1'b0, "R10", "config clears error", db_err, 0);
    en_mask = '1; p_valid = 60; p_ready = 70; p_db = 15; auto_db = 1'b1;
    repeat (4000) step();
    drain();
    @(negedge clk);
    chk(q_rd == q_wr, "R2", "all granted records written", q_rd, q_wr);

    // random traffic on a 2-slot ring, steady memory
    configure(2, 32'h0000_3000);
    en_mask = '1; p_valid = 80; p_ready = 100; p_db = 40; auto_db = 1'b1;
    repeat (1000) step();
    drain();
    @(negedge clk);
    chk(q_rd == q_wr, "R2", "small ring records written", q_rd, q_wr);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule